// File: doc/BRIEF.md
# Fuzzy Speed Controller Core

This block turns a speed setpoint and a measured speed into one crisp drive value per sample. When a one-cycle sample strobe arrives, it forms the tracking error and how much that error has changed since the last accepted sample. Both quantities are graded against seven evenly spaced triangular sets. Only the two neighbouring sets that cover each input are kept, so at most four rules of the seven-by-seven base are looked up. Each rule's weight is the product of its two grades. The result is the weight-averaged consequent value of those rules, and a sequential divider forms the quotient.

The consequent values sit in a 49-entry table. A write port can change any entry at any time, which lets an outer adaptation loop move the rule outputs while the controller runs. With every result, the block reports which four rule slots it used and which of them carried nonzero weight. The adaptation logic uses this to choose the entries to adjust.

Top module: `fz_speed_ctrl`

## Requirements
- R1: After reset, `u_o` is 0, `done_o` is 0 and `rule_vld_o` is 0. The stored previous error is 0.
- R2: On an accepted strobe the error is e = `ref_i` − `meas_i`, and the change is d = e − (error of the previously accepted sample).
- R3: With spacing S = 2^SH (256 by default), set k (0..6) peaks at (k−3)·S. For p = x + 3S strictly between 0 and 6S, the lower set is floor(p/S), with grade S − (p mod S). The next set up has grade p mod S.
- R4: For p ≤ 0 the lower set is 0, with grade S, and set 1 has grade 0. For p ≥ 6S the lower set is 5, with grade 0, and set 6 has grade S.
- R5: Rule index = 7·(error set) + (change set). The four 6-bit slots in `rule_idx_o` are packed from bit 0 upward: (le,ld), (le,ld+1), (le+1,ld), (le+1,ld+1). Bit g of `rule_vld_o` is 1 exactly when slot g has nonzero weight.
- R6: The weight of a slot is the product of its two grades. `u_o` is Σw·c / Σw, truncated toward zero, and it is 0 if Σw = 0.
- R7: After reset, table entry r holds (r/7 + r%7 − 6)·CSTEP (CSTEP = 1024 by default).
- R8: A write with `cw_en_i` high and `cw_addr_i` below 49 replaces that entry. Every later sample uses the new value.
- R9: Each accepted strobe produces exactly one `done_o` pulse of one cycle. A strobe that arrives before that pulse is ignored: it yields no pulse and does not change the stored previous error.
- R10: `u_o`, `rule_idx_o` and `rule_vld_o` change only in a cycle where `done_o` is high, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | One-cycle sample strobe |
| ref_i | input | DW | Speed setpoint, signed |
| meas_i | input | DW | Measured speed, signed |
| cw_en_i | input | 1 | Consequent table write enable |
| cw_addr_i | input | 6 | Table entry to write |
| cw_data_i | input | CW | Signed value to write |
| u_o | output | CW | Signed crisp control output |
| done_o | output | 1 | One-cycle result-valid pulse |
| rule_idx_o | output | 24 | Four 6-bit rule indices, slot 0 in the low bits |
| rule_vld_o | output | 4 | Nonzero-weight flag per slot |

## Verification
The bench targets the grading breakpoints at exactly ±3S and just inside them. A design with an off-by-one there would pick the wrong lower set, or give the outer set a zero grade while its neighbour got the full grade, and the rule indices would then point one row or column away. Negative weighted sums check that rounding goes toward zero, not toward minus infinity. The very first sample after reset checks that the change equals the error. A strobe injected while the divider is running checks that the previous error stays untouched: a design that latched it would report a wrong change on the following sample. Writes made to the table between samples must show up in the next result, not one sample late.

// File: rtl/fz_pkg.sv
package fz_pkg;
    localparam int NSETS  = 7;
    localparam int NRULES = NSETS * NSETS;
    localparam int NACT   = 4;
    localparam int RIW    = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_DIV
    } fz_state_e;
endpackage

// File: rtl/fz_fuzzify.sv
module fz_fuzzify #(
    parameter int IW = 17,
    parameter int SH = 8
) (
    input  logic signed [IW-1:0] x_i,
    output logic [2:0]           idx_o,
    output logic [SH:0]          mu_lo_o,
    output logic [SH:0]          mu_hi_o
);
    localparam int FULL = 1 << SH;
    localparam logic signed [IW+1:0] OFS   = (IW+2)'(3 * FULL);
    localparam logic signed [IW+1:0] TOP   = (IW+2)'(6 * FULL);
    localparam logic [SH:0]          MFULL = (SH+1)'(FULL);

    logic signed [IW+1:0] pos;
    logic [SH-1:0]        frac;

    // shift so that the leftmost peak lands on zero
    assign pos  = (IW+2)'(x_i) + OFS;
    assign frac = pos[SH-1:0];

    always_comb begin
        if (pos[IW+1] || pos == '0) begin
            idx_o   = 3'd0;
            mu_lo_o = MFULL;
            mu_hi_o = '0;
        end else if (pos >= TOP) begin
            idx_o   = 3'd5;
            mu_lo_o = '0;
            mu_hi_o = MFULL;
        end else begin
            idx_o   = 3'(pos >>> SH);
            mu_lo_o = MFULL - {1'b0, frac};
            mu_hi_o = {1'b0, frac};
        end
    end
endmodule

// File: rtl/fz_ctab.sv
module fz_ctab
    import fz_pkg::*;
#(
    parameter int CW    = 16,
    parameter int CSTEP = 1024
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_en_i,
    input  logic [RIW-1:0] wr_addr_i,
    input  logic [CW-1:0]  wr_data_i,
    input  logic [RIW-1:0] rd_addr_i [NACT],
    output logic [CW-1:0]  rd_data_o [NACT]
);
    logic [CW-1:0] mem_q [NRULES];

    function automatic logic [CW-1:0] reset_val(int r);
        return CW'((r / NSETS + r % NSETS - (NSETS - 1)) * CSTEP);
    endfunction

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int r = 0; r < NRULES; r++) mem_q[r] <= reset_val(r);
        end else if (wr_en_i && wr_addr_i < RIW'(NRULES)) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    for (genvar g = 0; g < NACT; g++) begin : g_rd
        assign rd_data_o[g] = mem_q[rd_addr_i[g]];
    end
endmodule

// File: rtl/fz_div.sv
module fz_div #(
    parameter int NW = 37,
    parameter int DW = 20
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic [NW-1:0] quo_o,
    output logic          done_o
);
    localparam int CNTW = $clog2(NW + 1);

    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] cnt;
        logic [DW:0]     rem;
        logic [NW-1:0]   quo;
        logic [DW-1:0]   den;
        logic            done;
    } div_t;

    div_t s_d, s_q;
    logic [DW:0] rem_sh;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        rem_sh   = {s_q.rem[DW-1:0], s_q.quo[NW-1]};
        if (start_i && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNTW'(NW);
            s_d.rem  = '0;
            s_d.quo  = num_i;
            s_d.den  = den_i;
        end else if (s_q.busy) begin
            s_d.quo = {s_q.quo[NW-2:0], 1'b0};
            if (rem_sh >= {1'b0, s_q.den}) begin
                s_d.rem    = rem_sh - {1'b0, s_q.den};
                s_d.quo[0] = 1'b1;
            end else begin
                s_d.rem = rem_sh;
            end
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CNTW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign quo_o  = (s_q.den == '0) ? '0 : s_q.quo;
    assign done_o = s_q.done;
endmodule

// File: rtl/fz_speed_ctrl.sv
module fz_speed_ctrl
    import fz_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int SH    = 8,
    parameter int CSTEP = 1024
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sample_i,
    input  logic signed [DW-1:0]  ref_i,
    input  logic signed [DW-1:0]  meas_i,
    input  logic                  cw_en_i,
    input  logic [RIW-1:0]        cw_addr_i,
    input  logic [CW-1:0]         cw_data_i,
    output logic signed [CW-1:0]  u_o,
    output logic                  done_o,
    output logic [NACT*RIW-1:0]   rule_idx_o,
    output logic [NACT-1:0]       rule_vld_o
);
    localparam int EW   = DW + 1;
    localparam int DEW  = DW + 2;
    localparam int MUW  = SH + 1;
    localparam int WW   = 2 * MUW;
    localparam int DENW = WW + 2;
    localparam int NUMW = WW + 1 + CW + 2;

    typedef struct packed {
        fz_state_e                  st;
        logic signed [EW-1:0]       err;
        logic signed [EW-1:0]       err_prev;
        logic signed [DEW-1:0]      derr;
        logic [NACT-1:0][RIW-1:0]   ridx;
        logic [NACT-1:0]            rvld;
        logic                       neg;
        logic signed [CW-1:0]       u;
        logic [NACT-1:0][RIW-1:0]   ridx_out;
        logic [NACT-1:0]            rvld_out;
        logic                       done;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [2:0]            idx_e, idx_d;
    logic [MUW-1:0]        mue_lo, mue_hi, mud_lo, mud_hi;
    logic [RIW-1:0]        slot_addr [NACT];
    logic [CW-1:0]         slot_cen  [NACT];
    logic [WW-1:0]         slot_w    [NACT];
    logic signed [NUMW-1:0] slot_term [NACT];
    logic signed [NUMW-1:0] num_sum;
    logic [DENW-1:0]       den_sum;
    logic [NUMW-1:0]       num_mag;
    logic [NUMW-1:0]       quo;
    logic                  div_start, div_done;
    logic signed [EW-1:0]  err_new;

    fz_fuzzify #(.IW(EW), .SH(SH)) u_fz_err (
        .x_i(s_q.err), .idx_o(idx_e), .mu_lo_o(mue_lo), .mu_hi_o(mue_hi)
    );

    fz_fuzzify #(.IW(DEW), .SH(SH)) u_fz_derr (
        .x_i(s_q.derr), .idx_o(idx_d), .mu_lo_o(mud_lo), .mu_hi_o(mud_hi)
    );

    fz_ctab #(.CW(CW), .CSTEP(CSTEP)) u_ctab (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(cw_en_i), .wr_addr_i(cw_addr_i), .wr_data_i(cw_data_i),
        .rd_addr_i(slot_addr), .rd_data_o(slot_cen)
    );

    // slot g: error row offset g/2, change column offset g%2
    for (genvar g = 0; g < NACT; g++) begin : g_slot
        localparam int EH = g / 2;
        localparam int DH = g % 2;
        logic [MUW-1:0] mu_e, mu_d;
        assign mu_e = (EH == 1) ? mue_hi : mue_lo;
        assign mu_d = (DH == 1) ? mud_hi : mud_lo;
        assign slot_w[g]    = WW'(mu_e) * WW'(mu_d);
        assign slot_addr[g] = (RIW'(idx_e) + RIW'(EH)) * RIW'(NSETS)
                            + RIW'(idx_d) + RIW'(DH);
        assign slot_term[g] = NUMW'($signed({1'b0, slot_w[g]}))
                            * NUMW'($signed(slot_cen[g]));
    end

    assign num_sum = slot_term[0] + slot_term[1] + slot_term[2] + slot_term[3];
    assign den_sum = DENW'(slot_w[0]) + DENW'(slot_w[1])
                   + DENW'(slot_w[2]) + DENW'(slot_w[3]);
    assign num_mag = num_sum[NUMW-1] ? NUMW'(-num_sum) : NUMW'(num_sum);
    assign err_new = EW'(ref_i) - EW'(meas_i);

    fz_div #(.NW(NUMW), .DW(DENW)) u_div (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
        .num_i(num_mag), .den_i(den_sum), .quo_o(quo), .done_o(div_done)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        div_start = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (sample_i) begin
                    s_d.err      = err_new;
                    s_d.derr     = DEW'(err_new) - DEW'(s_q.err_prev);
                    s_d.err_prev = err_new;
                    s_d.st       = ST_CALC;
                end
            end
            ST_CALC: begin
                div_start = 1'b1;
                for (int g = 0; g < NACT; g++) begin
                    s_d.ridx[g] = slot_addr[g];
                    s_d.rvld[g] = (slot_w[g] != '0);
                end
                s_d.neg = num_sum[NUMW-1];
                s_d.st  = ST_DIV;
            end
            ST_DIV: begin
                if (div_done) begin
                    s_d.u        = s_q.neg ? -CW'(quo) : CW'(quo);
                    s_d.ridx_out = s_q.ridx;
                    s_d.rvld_out = s_q.rvld;
                    s_d.done     = 1'b1;
                    s_d.st       = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign u_o        = s_q.u;
    assign done_o     = s_q.done;
    assign rule_idx_o = s_q.ridx_out;
    assign rule_vld_o = s_q.rvld_out;
endmodule

// File: rtl/fz_speed_ctrl_chk.sv
module fz_speed_ctrl_chk #(
    parameter int CW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          sample_i,
    input logic          done_o,
    input logic [CW-1:0] u_o,
    input logic [23:0]   rule_idx_o,
    input logic [3:0]    rule_vld_o
);
    logic pend_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                          pend_q <= 1'b0;
        else if (sample_i && (!pend_q || done_o)) pend_q <= 1'b1;
        else if (done_o)                      pend_q <= 1'b0;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);  // R9
    AST_DONE_NEEDS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> pend_q);  // R9
    AST_U_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(u_o));  // R10
    AST_RULES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(rule_idx_o) && $stable(rule_vld_o)));  // R10
    AST_ACTIVE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($countones(rule_vld_o) == 1 || $countones(rule_vld_o) == 2
                    || $countones(rule_vld_o) == 4));  // R5
    AST_SLOT_LAYOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (rule_idx_o[11:6] == rule_idx_o[5:0] + 6'd1
                    && rule_idx_o[17:12] == rule_idx_o[5:0] + 6'd7
                    && rule_idx_o[23:18] == rule_idx_o[5:0] + 6'd8));  // R5
endmodule

bind fz_speed_ctrl fz_speed_ctrl_chk #(.CW(CW)) u_chk (.*);

// File: tb/fz_speed_ctrl_tb.sv
module fz_speed_ctrl_tb;
    localparam int S = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample = 1'b0;
    logic signed [15:0] ref_v = '0;
    logic signed [15:0] meas_v = '0;
    logic        cw_en = 1'b0;
    logic [5:0]  cw_addr = '0;
    logic [15:0] cw_data = '0;
    logic signed [15:0] u;
    logic        done;
    logic [23:0] ridx;
    logic [3:0]  rvld;

    int n_chk = 0;
    int n_err = 0;
    int cen [49];
    int prev_err = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    fz_speed_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .ref_i(ref_v),
        .meas_i(meas_v), .cw_en_i(cw_en), .cw_addr_i(cw_addr),
        .cw_data_i(cw_data), .u_o(u), .done_o(done),
        .rule_idx_o(ridx), .rule_vld_o(rvld)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // grading per R3/R4
    task automatic grade(int x, output int lo_idx, output int mlo, output int mhi);
        int p;
        p = x + 3 * S;
        if (p <= 0) begin
            lo_idx = 0; mlo = S; mhi = 0;
        end else if (p >= 6 * S) begin
            lo_idx = 5; mlo = 0; mhi = S;
        end else begin
            lo_idx = p / S; mlo = S - p % S; mhi = p % S;
        end
    endtask

    task automatic model(int e, int d, output int eu, output int eidx[4], output int evld);
        int ie, me0, me1, id, md0, md1;
        longint w[4];
        longint num, den;
        grade(e, ie, me0, me1);
        grade(d, id, md0, md1);
        w[0] = me0 * md0; w[1] = me0 * md1; w[2] = me1 * md0; w[3] = me1 * md1;
        eidx[0] = ie * 7 + id;       eidx[1] = ie * 7 + id + 1;
        eidx[2] = (ie + 1) * 7 + id; eidx[3] = (ie + 1) * 7 + id + 1;
        num = 0; den = 0; evld = 0;
        for (int g = 0; g < 4; g++) begin
            num += w[g] * cen[eidx[g]];
            den += w[g];
            if (w[g] != 0) evld |= (1 << g);
        end
        eu = (den == 0) ? 0 : int'(num / den);  // truncates toward zero
    endtask

    task automatic write_centre(int a, int v);
        @(negedge clk);
        cw_en = 1'b1; cw_addr = 6'(a); cw_data = 16'(v);
        @(negedge clk);
        cw_en = 1'b0;
        cen[a] = v;
    endtask

    task automatic run_sample(int rf, int ms, bit extra, string tag);
        int e, d, eu, evld, n, extra_done;
        int eidx[4];
        e = rf - ms;
        d = e - prev_err;
        prev_err = e;
        model(e, d, eu, eidx, evld);
        @(negedge clk);
        sample = 1'b1; ref_v = 16'(rf); meas_v = 16'(ms);
        @(negedge clk);
        sample = 1'b0;
        if (extra) begin
            repeat (3) @(negedge clk);
            sample = 1'b1; ref_v = 16'(rf + 900); meas_v = 16'(ms - 700);
            @(negedge clk);
            sample = 1'b0;
        end
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(n < 200, {tag, " R9 done seen"}, n, 0);
        chk(u == 16'(eu), {tag, " R6 output"}, u, eu);
        for (int g = 0; g < 4; g++)
            chk(ridx[g*6 +: 6] == 6'(eidx[g]), {tag, " R5 rule index"}, ridx[g*6 +: 6], eidx[g]);
        chk(rvld == 4'(evld), {tag, " R5 valid mask"}, rvld, evld);
        @(negedge clk);
        chk(!done, {tag, " R9 pulse width"}, done, 0);
        if (extra) begin
            extra_done = 0;
            repeat (80) begin
                @(negedge clk);
                if (done) extra_done++;
            end
            chk(extra_done == 0, {tag, " R9 busy strobe ignored"}, extra_done, 0);
        end
    endtask

    initial begin
        int r1, r2;
        void'($urandom(32'd4242));
        for (int r = 0; r < 49; r++) cen[r] = (r / 7 + r % 7 - 6) * 1024;  // R7
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(u == 0, "R1 reset output", u, 0);
        chk(!done, "R1 reset done", done, 0);
        chk(rvld == 0, "R1 reset mask", rvld, 0);

        run_sample(0, 0, 0, "R2 zero error");
        run_sample(300, 100, 0, "R3 interior");
        run_sample(300, 100, 0, "R2 zero change");
        run_sample(2000, -1000, 0, "R4 high saturation R7");
        run_sample(-2000, 2000, 0, "R4 low saturation R7");
        run_sample(768, 0, 0, "R4 upper edge");
        run_sample(-768, 0, 0, "R4 lower edge");
        run_sample(767, 0, 0, "R3 just inside top");
        run_sample(-767, 0, 0, "R3 just inside bottom");
        write_centre(24, 1234);
        run_sample(0, 0, 0, "R8 prime");
        run_sample(0, 0, 0, "R8 written centre");
        run_sample(-150, 40, 1, "R9 busy strobe");
        run_sample(220, -90, 0, "R9 prev error kept");
        write_centre(17, -3001);
        run_sample(-130, 0, 0, "R6 negative trunc");

        for (int i = 0; i < 300; i++) begin
            if (i % 5 == 0) write_centre(int'($urandom % 49), int'($urandom % 16001) - 8000);
            r1 = int'($urandom % 2401) - 1200;
            r2 = int'($urandom % 2401) - 1200;
            run_sample(r1, r2, (i % 37 == 0), "R6 random");
        end
        finish_run();
    end
endmodule